// File: doc/BRIEF.md
# Smartcard character transmitter with automatic retry

This block is the sending half of a character-mode smartcard serial link. It takes one byte at a time over a valid/ready handshake and adds a parity bit of a selectable sense. It sends the character on a single open-drain line that the card can also pull low. The block never drives the line high. It pulls the line low for a 0 and releases it for a 1, and all timing follows an oversampling tick supplied from outside.

After the parity bit the line stays released for one and a half bit times. The line is read once, in the middle of the final bit of that period. If the card holds it low there, the card has rejected the character. In that case the same character is sent again after a gap of two and a half bit times, up to a programmable number of retries. If every retry is rejected, a sticky framing-error flag is raised. If the first attempt is accepted, the completion flag waits for a programmable number of guard bit times. If a retried attempt is accepted, the completion flag rises at once.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, tx_done and byte_ready are 1, and line_oe and frame_err are 0.
- R2: An accepted byte is preceded by OVS/2 released ticks, then sent as start bit 0, data bits LSB first, then parity, each lasting OVS ticks. line_oe=1 means the line is pulled low (bit value 0).
- R3: odd_par is captured when the byte is accepted. With odd_par=0 the count of ones in data plus parity is even; with odd_par=1 it is odd.
- R4: After parity, the line is released for OVS+OVS/2 ticks. line_in is read once, on the OVS-th tick of that period, and a low level there is a rejection.
- R5: When the first attempt is accepted, tx_done and byte_ready stay 0 for guard_bits·OVS ticks after the stop period and then rise. With guard_bits=0 they rise at the end of the stop period.
- R6: A rejection while fewer than retry_max retries are used releases the line for 2·OVS+OVS/2 ticks and then resends the same frame with the same parity, starting at the start bit.
- R7: When a retried attempt is accepted, tx_done rises at the end of its stop period with no guard time.
- R8: A rejection after retry_max retries sets frame_err and stops transmission. tx_done, byte_ready and line_oe then stay 0.
- R9: frame_err stays 1 until err_clr is 1 at a clock edge. That edge clears it and sets tx_done and byte_ready.
- R10: A low level on line_in at any point other than the rejection sample point has no effect on the frame or on completion.
- R11: Timing advances only on cycles where tick is 1. With tick held at 0, line_oe does not change.
- R12: byte_valid is ignored while byte_ready is 0, both during a character and while frame_err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick, OVS per bit time |
| byte_in | input | 8 | Byte to send |
| byte_valid | input | 1 | byte_in is valid |
| byte_ready | output | 1 | A byte can be accepted |
| guard_bits | input | GUARD_W | Guard time in bit times after a first-attempt success |
| retry_max | input | RETRY_W | Number of retries allowed |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| line_in | input | 1 | Level read back from the shared line |
| line_oe | output | 1 | 1 pulls the shared line low |
| tx_done | output | 1 | Transmission complete |
| frame_err | output | 1 | Sticky error: retries exhausted |
| err_clr | input | 1 | Clears frame_err |

## Verification
The bench builds the block with OVS=4, GUARD_W=4 and RETRY_W=2. With these values a bit lasts four ticks, so each bit can be checked at its middle. The stop period, the 10-tick retry gap and guard times of several bits all fit into short tests. A retry limit of 0, 1 or 2 reaches the immediate error, the error after a single retry, and a success on a retry. With tick held at 1 the tick count equals the cycle count, which keeps the expected edges easy to count. A separate test holds tick low to cover the gating.

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int OVS     = 16,
  parameter int GUARD_W = 8,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [7:0]         byte_in,
  input  logic               byte_valid,
  output logic               byte_ready,
  input  logic [GUARD_W-1:0] guard_bits,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               odd_par,
  input  logic               line_in,
  output logic               line_oe,
  output logic               tx_done,
  output logic               frame_err,
  input  logic               err_clr
);
  localparam int HALF     = OVS / 2;
  localparam int STOP_LEN = OVS + HALF;
  localparam int GAP_LEN  = 2 * OVS + HALF;
  localparam int CW       = $clog2(GAP_LEN);
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0] BIT_END  = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP_END = CW'(STOP_LEN - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(GAP_LEN - 1);

  typedef enum logic [2:0] {IDLE, LEAD, BITS, STOP, GAP, GUARD} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [3:0]        bidx;
  logic [9:0]        frm;
  logic [RETRY_W-1:0] rcnt;
  logic [GUARD_W-1:0] gcnt;
  logic              nack;

  assign byte_ready = (st == IDLE) && !frame_err;
  assign line_oe    = (st == BITS) && !frm[bidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; bidx <= '0; frm <= '1; rcnt <= '0;
      gcnt <= '0; nack <= 1'b0; tx_done <= 1'b1; frame_err <= 1'b0;
    end else begin
      if (err_clr && frame_err) begin
        frame_err <= 1'b0;
        tx_done   <= 1'b1;
      end
      case (st)
        IDLE: if (byte_valid && byte_ready) begin
          frm     <= {^byte_in ^ odd_par, byte_in, 1'b0};
          rcnt    <= '0;
          cnt     <= '0;
          tx_done <= 1'b0;
          st      <= LEAD;
        end
        LEAD: if (tick) begin
          if (cnt == HALF_END) begin
            cnt <= '0; bidx <= '0; st <= BITS;
          end else cnt <= cnt + 1'b1;
        end
        BITS: if (tick) begin
          if (cnt == BIT_END) begin
            cnt <= '0;
            if (bidx == 4'd9) st <= STOP;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        STOP: if (tick) begin
          if (cnt == BIT_END) nack <= !line_in;
          if (cnt == STOP_END) begin
            cnt <= '0;
            if (nack) begin
              if (rcnt == retry_max) begin
                frame_err <= 1'b1;
                st        <= IDLE;
              end else begin
                rcnt <= rcnt + 1'b1;
                st   <= GAP;
              end
            end else if (rcnt != '0 || guard_bits == '0) begin
              tx_done <= 1'b1;
              st      <= IDLE;
            end else begin
              gcnt <= '0;
              st   <= GUARD;
            end
          end else cnt <= cnt + 1'b1;
        end
        GAP: if (tick) begin
          if (cnt == GAP_END) begin
            cnt <= '0; bidx <= '0; st <= BITS;
          end else cnt <= cnt + 1'b1;
        end
        GUARD: if (tick) begin
          if (cnt == BIT_END) begin
            cnt <= '0;
            if (gcnt + 1'b1 == guard_bits) begin
              tx_done <= 1'b1;
              st      <= IDLE;
            end else gcnt <= gcnt + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R12
  accept_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready) |=> !tx_done);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !err_clr) |=> frame_err);
  // R8
  err_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!byte_ready && !line_oe));
  // R8
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !tx_done);
  // R5
  done_means_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (byte_ready && !line_oe));
  // R11
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && st != IDLE) |=> $stable(line_oe));
endmodule

// File: tb/sc_char_tx_bench.sv
module sc_char_tx_bench;
  localparam int OVS = 4;
  localparam int GW  = 4;
  localparam int RW  = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [7:0] byte_in = '0;
  logic byte_valid = 1'b0, odd_par = 1'b0, line_in = 1'b1, err_clr = 1'b0;
  logic [GW-1:0] guard_bits = '0;
  logic [RW-1:0] retry_max = '0;
  logic byte_ready, line_oe, tx_done, frame_err;
  int vecs = 0, errs = 0;

  always #2 clk = ~clk;

  sc_char_tx #(.OVS(OVS), .GUARD_W(GW), .RETRY_W(RW)) u_sc_char_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .byte_in(byte_in),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .guard_bits(guard_bits),
    .retry_max(retry_max), .odd_par(odd_par), .line_in(line_in),
    .line_oe(line_oe), .tx_done(tx_done), .frame_err(frame_err), .err_clr(err_clr));

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit odd);
    byte_in = b; odd_par = odd; byte_valid = 1'b1;
    cyc(1);
    byte_valid = 1'b0;
    chk("R12", "ready after accept", int'(byte_ready), 0);
  endtask

  // Starts at the negedge after the edge that begins the start bit.
  task automatic run_frame(input logic [7:0] b, input bit odd, input bit nack,
                           input bit spur, input string req);
    logic par;
    par = ^b ^ odd;
    for (int k = 0; k < 10; k++) begin
      logic bv;
      bv = (k == 0) ? 1'b0 : (k <= 8) ? b[k-1] : par;
      if (spur && k == 3) line_in = 1'b0;
      if (spur && k == 5) line_in = 1'b1;
      cyc(2);
      chk(k == 9 ? "R3" : req, $sformatf("bit %0d oe", k), int'(line_oe), int'(!bv));
      cyc(2);
    end
    if (spur) line_in = 1'b0;
    cyc(1);
    chk("R4", "stop released", int'(line_oe), 0);
    cyc(1);
    if (spur) line_in = 1'b1;
    if (nack) line_in = 1'b0;
    cyc(3);
    line_in = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset;
    chk("R1", "done", int'(tx_done), 1);
    chk("R1", "ready", int'(byte_ready), 1);
    chk("R1", "oe", int'(line_oe), 0);
    chk("R1", "err", int'(frame_err), 0);
  endtask

  task automatic t_even_guard;
    guard_bits = 4'd3; retry_max = 2'd2;
    send(8'hA5, 1'b0);
    chk("R2", "lead released", int'(line_oe), 0);
    byte_in = 8'hFF; byte_valid = 1'b1;
    cyc(2);
    run_frame(8'hA5, 1'b0, 1'b0, 1'b0, "R2");
    byte_valid = 1'b0;
    chk("R5", "done in guard", int'(tx_done), 0);
    cyc(11);
    chk("R5", "done before guard end", int'(tx_done), 0);
    cyc(1);
    chk("R5", "done after guard", int'(tx_done), 1);
    chk("R5", "ready after guard", int'(byte_ready), 1);
  endtask

  task automatic t_odd_noguard;
    guard_bits = '0;
    send(8'h3C, 1'b1);
    cyc(2);
    run_frame(8'h3C, 1'b1, 1'b0, 1'b0, "R3");
    chk("R5", "done with zero guard", int'(tx_done), 1);
  endtask

  task automatic t_retry_ok;
    guard_bits = 4'd5; retry_max = 2'd2;
    send(8'h5A, 1'b0);
    cyc(2);
    run_frame(8'h5A, 1'b0, 1'b1, 1'b0, "R6");
    chk("R6", "done after nack", int'(tx_done), 0);
    cyc(5);
    chk("R6", "gap released", int'(line_oe), 0);
    cyc(4);
    chk("R6", "gap still released", int'(line_oe), 0);
    cyc(1);
    run_frame(8'h5A, 1'b0, 1'b0, 1'b0, "R6");
    chk("R7", "done no guard after retry", int'(tx_done), 1);
    chk("R7", "err", int'(frame_err), 0);
  endtask

  task automatic clear_err;
    err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;
    chk("R9", "err cleared", int'(frame_err), 0);
    chk("R9", "done after clear", int'(tx_done), 1);
    chk("R9", "ready after clear", int'(byte_ready), 1);
  endtask

  task automatic t_exhaust;
    retry_max = 2'd1; guard_bits = '0;
    send(8'hC3, 1'b0);
    cyc(2);
    run_frame(8'hC3, 1'b0, 1'b1, 1'b0, "R6");
    cyc(10);
    run_frame(8'hC3, 1'b0, 1'b1, 1'b0, "R6");
    chk("R8", "err set", int'(frame_err), 1);
    chk("R8", "done low", int'(tx_done), 0);
    chk("R8", "ready low", int'(byte_ready), 0);
    byte_in = 8'h00; byte_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      chk("R12", "no drive while err", int'(line_oe), 0);
    end
    byte_valid = 1'b0;
    chk("R9", "err held", int'(frame_err), 1);
    chk("R9", "done held low", int'(tx_done), 0);
    clear_err();
  endtask

  task automatic t_zero_retry;
    retry_max = '0;
    send(8'h81, 1'b1);
    cyc(2);
    run_frame(8'h81, 1'b1, 1'b1, 1'b0, "R2");
    chk("R8", "err with zero retries", int'(frame_err), 1);
    cyc(3);
    chk("R8", "oe after stop", int'(line_oe), 0);
    clear_err();
  endtask

  task automatic t_spurious;
    retry_max = 2'd2; guard_bits = '0;
    send(8'h6E, 1'b0);
    cyc(2);
    run_frame(8'h6E, 1'b0, 1'b0, 1'b1, "R10");
    chk("R10", "done despite spurious low", int'(tx_done), 1);
    chk("R10", "err", int'(frame_err), 0);
  endtask

  task automatic t_gate;
    guard_bits = '0;
    send(8'h01, 1'b0);
    cyc(2);
    tick = 1'b0;
    cyc(4);
    chk("R11", "start held while gated", int'(line_oe), 1);
    cyc(4);
    chk("R11", "start still held", int'(line_oe), 1);
    tick = 1'b1;
    run_frame(8'h01, 1'b0, 1'b0, 1'b0, "R11");
    chk("R11", "done after gated frame", int'(tx_done), 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_even_guard();
    t_odd_noguard();
    t_retry_ok();
    t_exhaust();
    t_zero_retry();
    t_spurious();
    t_gate();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule